// File: doc/BRIEF.md
# Stop Mode Clock Wake Controller

This block handles the deepest low-power state of a small controller with one fast and one slow oscillator. Software first arms an unlock latch by writing two key bytes, then writes the stop request. Two cycles later both oscillator enables drop and every downstream clock gate closes. The controller stays in this state until the non-maskable interrupt or an unmasked external pin interrupt arrives.

On wake, both oscillators are re-enabled together. Each clock domain then reopens on its own schedule. First it waits for its oscillator's ready input, which stands in for the analog start-up phase. Then it counts 8192 qualified oscillator edges. The fast gates and the run flag come back first. The slow gate follows whenever its own count completes.

A wake that arrives during the two-cycle entry delay aborts the entry, and no gate ever closes.

Top module: `stop_wake_ctrl`

## Requirements
- R1: A control write (wr_addr_i=1) with data bit 0 set while the unlock is not armed leaves the block in run mode: stop_bit_o stays 0 and all enables and gates stay 1.
- R2: The unlock arms only after a write of 0x5A followed by a write of 0xA5 to the key register (wr_addr_i=0). Any other key value or order disarms it, and every accepted stop entry disarms it.
- R3: In stop mode, hs_osc_en_o, ls_osc_en_o, osc_clk_gate_o, hs_sys_gate_o, ls_gate_o and run_o are all 0.
- R4: An accepted stop write at clock edge N sets stop_bit_o after edge N. The oscillator enables fall after edge N+2 and not earlier.
- R5: Wake sources are nmi_i and any pin i with pin_irq_i[i] and pin_ie_i[i] both 1. A pin request whose enable is 0 leaves the block stopped.
- R6: The edge that samples a wake in stop mode clears stop_bit_o and raises both oscillator enables together, while all gates stay closed.
- R7: The oscillator clock gate and the fast system gate reopen after the edge at which the 8192nd fast edge is counted. An edge is counted only when hs_edge_i and hs_ready_i are both 1 while the enable is high.
- R8: ls_gate_o reopens independently, after 8192 counted slow edges (ls_edge_i with ls_ready_i high). Once open, the gate stays open while its oscillator stays enabled.
- R9: run_o rises in the same cycle as the fast gates reopen and is 0 from stop entry until then.
- R10: A wake sampled at either edge of the two-cycle entry delay cancels the entry. stop_bit_o returns to 0 and no enable or gate ever drops.
- R11: After reset, both enables and all gates are 1, run_o is 1, stop_bit_o is 0 and the unlock is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0 = key register, 1 = control register |
| wr_data_i | input | DATA_W | Write data; control bit 0 is the stop request |
| nmi_i | input | 1 | Non-maskable wake request |
| pin_irq_i | input | NUM_PINS | External pin interrupt requests |
| pin_ie_i | input | NUM_PINS | Per-pin interrupt enables |
| hs_edge_i | input | 1 | Fast oscillator edge strobe |
| hs_ready_i | input | 1 | Fast oscillator start phase complete |
| ls_edge_i | input | 1 | Slow oscillator edge strobe |
| ls_ready_i | input | 1 | Slow oscillator start phase complete |
| hs_osc_en_o | output | 1 | Fast oscillator enable |
| ls_osc_en_o | output | 1 | Slow oscillator enable |
| osc_clk_gate_o | output | 1 | Fast oscillator clock gate to peripherals |
| hs_sys_gate_o | output | 1 | Fast system clock gate |
| ls_gate_o | output | 1 | Slow clock gate |
| stop_bit_o | output | 1 | Current stop request bit |
| run_o | output | 1 | Run-mode indication |

## Verification
Two events can collide in the same cycle: a wake request and the pending stop entry, when a request lands in either cycle of the two-cycle delay. The bench raises the non-maskable interrupt at the first and then at the second delay edge. It expects the stop bit to clear and every enable and gate to stay high throughout. A second collision is the fast domain reopening while the slow domain is still counting. A per-cycle model of both edge counters judges each gate at every cycle, and the bench checks that run returns while the slow gate is still shut.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_ENT0, ST_ENT1, ST_STOP, ST_WAKE
  } stop_state_e;

  typedef enum logic [1:0] {
    KEY_IDLE, KEY_HALF, KEY_ARMED
  } key_state_e;

  localparam logic       ADDR_KEY  = 1'b0;
  localparam logic       ADDR_CTRL = 1'b1;
  localparam logic [7:0] KEY_FIRST = 8'h5A;
  localparam logic [7:0] KEY_SECOND = 8'hA5;
  localparam int         STOP_POS  = 0;
endpackage

// File: rtl/stop_unlock.sv
module stop_unlock
  import stop_wake_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              consume_i,
  output logic              armed_o
);
  key_state_e key_q;
  logic key_wr, is_first, is_second;

  assign key_wr    = wr_en_i && (wr_addr_i == ADDR_KEY);
  assign is_first  = (wr_data_i == DATA_W'(KEY_FIRST));
  assign is_second = (wr_data_i == DATA_W'(KEY_SECOND));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= KEY_IDLE;
    end else if (consume_i) begin
      key_q <= KEY_IDLE;
    end else if (key_wr) begin
      if (is_first)                            key_q <= KEY_HALF;
      else if (is_second && key_q == KEY_HALF) key_q <= KEY_ARMED;
      else                                     key_q <= KEY_IDLE;
    end
  end

  assign armed_o = (key_q == KEY_ARMED);

  AST_ARM_NEEDS_SECOND_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_o) |-> $past(key_wr && is_second)); // R2
  AST_CONSUME_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i |=> !armed_o); // R2
endmodule

// File: rtl/osc_settle.sv
module osc_settle #(
  parameter int EDGES = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_en_i,
  input  logic ready_i,
  input  logic edge_i,
  output logic gate_o
);
  localparam int CNT_W = (EDGES > 1) ? $clog2(EDGES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(EDGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (!osc_en_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q && ready_i && edge_i) begin
      if (cnt_q == TERM) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign gate_o = done_q && osc_en_i;

  AST_GATE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> osc_en_i); // R3
  AST_OPEN_AT_TERMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(cnt_q) == TERM && $past(ready_i && edge_i))); // R7
  AST_COUNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && osc_en_i) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
  import stop_wake_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_addr_i,
  input  logic stop_req_i,
  input  logic armed_i,
  input  logic wake_i,
  input  logic hs_done_i,
  output logic consume_o,
  output logic stop_bit_o,
  output logic osc_en_o
);
  stop_state_e state_q;
  logic stop_q, osc_en_q, ctrl_stop;

  assign ctrl_stop = wr_en_i && (wr_addr_i == ADDR_CTRL) && stop_req_i;
  assign consume_o = ctrl_stop && armed_i && (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_RUN;
      stop_q   <= 1'b0;
      osc_en_q <= 1'b1;
    end else begin
      case (state_q)
        ST_RUN: if (consume_o) begin
          state_q <= ST_ENT0;
          stop_q  <= 1'b1;
        end
        ST_ENT0: if (wake_i) begin
          state_q <= ST_RUN;
          stop_q  <= 1'b0;
        end else begin
          state_q <= ST_ENT1;
        end
        ST_ENT1: if (wake_i) begin
          state_q <= ST_RUN;
          stop_q  <= 1'b0;
        end else begin
          state_q  <= ST_STOP;
          osc_en_q <= 1'b0;
        end
        ST_STOP: if (wake_i) begin
          state_q  <= ST_WAKE;
          stop_q   <= 1'b0;
          osc_en_q <= 1'b1;
        end
        ST_WAKE: if (hs_done_i) state_q <= ST_RUN;
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign stop_bit_o = stop_q;
  assign osc_en_o   = osc_en_q;

  AST_UNARMED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && ctrl_stop && !armed_i) |=> (state_q == ST_RUN && !stop_q)); // R1
  AST_STOP_OSC_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP) |-> (!osc_en_q && stop_q)); // R3
  AST_ENTRY_TWO_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && $past(state_q) != ST_STOP) |->
      ($past(state_q) == ST_ENT1 && $past(state_q, 2) == ST_ENT0)); // R4
  AST_WAKE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && wake_i) |=> (osc_en_q && !stop_q)); // R6
  AST_CANCEL_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_ENT0 || state_q == ST_ENT1) && wake_i) |=>
      (state_q == ST_RUN && osc_en_q && !stop_q)); // R10
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import stop_wake_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int NUM_PINS     = 4,
  parameter int SETTLE_EDGES = 8192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic                wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                nmi_i,
  input  logic [NUM_PINS-1:0] pin_irq_i,
  input  logic [NUM_PINS-1:0] pin_ie_i,
  input  logic                hs_edge_i,
  input  logic                hs_ready_i,
  input  logic                ls_edge_i,
  input  logic                ls_ready_i,
  output logic                hs_osc_en_o,
  output logic                ls_osc_en_o,
  output logic                osc_clk_gate_o,
  output logic                hs_sys_gate_o,
  output logic                ls_gate_o,
  output logic                stop_bit_o,
  output logic                run_o
);
  localparam int NUM_DOM = 2;  // 0 = fast, 1 = slow

  logic armed, consume, wake, osc_en;
  logic [NUM_DOM-1:0] edge_v, ready_v, gate_v;

  assign wake    = nmi_i || |(pin_irq_i & pin_ie_i);
  assign edge_v  = {ls_edge_i, hs_edge_i};
  assign ready_v = {ls_ready_i, hs_ready_i};

  stop_unlock #(.DATA_W(DATA_W)) u_unlock (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .consume_i (consume),
    .armed_o   (armed)
  );

  stop_fsm u_fsm (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i,
    .stop_req_i (wr_data_i[STOP_POS]),
    .armed_i    (armed),
    .wake_i     (wake),
    .hs_done_i  (gate_v[0]),
    .consume_o  (consume),
    .stop_bit_o (stop_bit_o),
    .osc_en_o   (osc_en)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    osc_settle #(.EDGES(SETTLE_EDGES)) u_settle (
      .clk_i, .rst_ni,
      .osc_en_i (osc_en),
      .ready_i  (ready_v[d]),
      .edge_i   (edge_v[d]),
      .gate_o   (gate_v[d])
    );
  end

  assign hs_osc_en_o    = osc_en;
  assign ls_osc_en_o    = osc_en;
  assign osc_clk_gate_o = gate_v[0];
  assign hs_sys_gate_o  = gate_v[0];
  assign ls_gate_o      = gate_v[1];
  assign run_o          = gate_v[0];

  AST_STOP_ALL_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs_osc_en_o |-> !(osc_clk_gate_o || ls_gate_o || run_o)); // R3
  AST_WAKE_BIT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_osc_en_o) |-> (!stop_bit_o && ls_osc_en_o && !ls_gate_o)); // R6
endmodule

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
  localparam int E = 8192;
  localparam int HS_START = 20;
  localparam int LS_START = 45;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       nmi = 1'b0;
  logic [3:0] pins = 4'h0, ie = 4'h0;
  logic       hs_edge = 1'b1, hs_ready = 1'b1, ls_edge = 1'b0, ls_ready = 1'b1;
  logic hs_en, ls_en, osc_gate, sys_gate, ls_gate, stop_bit, run;

  stop_wake_ctrl i_stop_wake_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .nmi_i(nmi), .pin_irq_i(pins), .pin_ie_i(ie),
    .hs_edge_i(hs_edge), .hs_ready_i(hs_ready), .ls_edge_i(ls_edge),
    .ls_ready_i(ls_ready), .hs_osc_en_o(hs_en), .ls_osc_en_o(ls_en),
    .osc_clk_gate_o(osc_gate), .hs_sys_gate_o(sys_gate), .ls_gate_o(ls_gate),
    .stop_bit_o(stop_bit), .run_o(run)
  );

  int checks = 0, errors = 0, mon_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  function automatic int next_arm(input int st, input logic [7:0] d);
    if (d == 8'h5A) return 1;
    if (d == 8'hA5 && st == 1) return 2;
    return 0;
  endfunction

  function automatic logic exp_wake(input logic n, input logic [3:0] p, input logic [3:0] e);
    return n || (|(p & e));
  endfunction

  // reference model of both settling counters plus oscillator start phases
  int m_hs = E, m_ls = E, hs_on = 0, ls_on = 0;
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (osc_gate !== (hs_en && m_hs >= E) || sys_gate !== (hs_en && m_hs >= E) ||
        run !== (hs_en && m_hs >= E)) begin
      errors++;
      if (mon_fail < 10) $display("FAIL R7 R9 fast gate/run act %0b%0b%0b exp %0b",
                                  osc_gate, sys_gate, run, hs_en && m_hs >= E);
      mon_fail++;
    end
    checks++;
    if (ls_gate !== (ls_en && m_ls >= E)) begin
      errors++;
      if (mon_fail < 10) $display("FAIL R8 slow gate act %0b exp %0b", ls_gate, ls_en && m_ls >= E);
      mon_fail++;
    end
    if (!hs_en) begin hs_on = 0; hs_ready = 1'b0; end
    else begin hs_on++; hs_ready = (hs_on > HS_START); end
    if (!ls_en) begin ls_on = 0; ls_ready = 1'b0; end
    else begin ls_on++; ls_ready = (ls_on > LS_START); end
    hs_edge = (($urandom % 8) != 0);
    ls_edge = ~ls_edge;
    m_hs = !hs_en ? 0 : (hs_ready && hs_edge && m_hs < E) ? m_hs + 1 : m_hs;
    m_ls = !ls_en ? 0 : (ls_ready && ls_edge && m_ls < E) ? m_ls + 1 : m_ls;
  end

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic arm();
    wr(1'b0, 8'h5A);
    wr(1'b0, 8'hA5);
  endtask

  task automatic wait_run(input string req);
    int n = 0;
    while (!run && n < 20000) begin @(negedge clk); n++; end
    chk(req, run, 1);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int arm_st;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 hs_en", hs_en, 1);   chk("R11 ls_en", ls_en, 1);
    chk("R11 gates", {osc_gate, sys_gate, ls_gate}, 3'b111);
    chk("R11 run", run, 1);       chk("R11 stop_bit", stop_bit, 0);
    // R1 stop without arming (also shows reset disarmed)
    wr(1'b1, 8'h01);
    chk("R1 stop_bit", stop_bit, 0);
    repeat (2) @(negedge clk);
    chk("R1 hs_en", hs_en, 1);
    // R2 wrong order and broken sequence
    wr(1'b0, 8'hA5); wr(1'b0, 8'h5A); wr(1'b0, 8'h33); wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    chk("R2 bad order", hs_en, 1);
    arm(); wr(1'b0, 8'h5A); wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    chk("R2 rewritten key", hs_en, 1);
    // R4 entry timing
    arm(); wr(1'b1, 8'h01);
    chk("R4 stop_bit after N", stop_bit, 1);
    chk("R4 en after N", hs_en, 1);
    @(negedge clk);
    chk("R4 en after N+1", hs_en, 1);
    @(negedge clk);
    chk("R3 enables after N+2", {hs_en, ls_en}, 2'b00);
    chk("R3 gates", {osc_gate, sys_gate, ls_gate, run}, 4'b0000);
    // R5 masked pin
    pins = 4'b0010; ie = 4'b1101;
    repeat (3) @(negedge clk);
    chk("R5 masked pin stays stopped", hs_en, 0);
    ie = 4'b0010;
    @(negedge clk);
    pins = 4'h0; ie = 4'h0;
    chk("R6 stop_bit cleared", stop_bit, 0);
    chk("R6 both enables", {hs_en, ls_en}, 2'b11);
    chk("R6 gates shut", {osc_gate, ls_gate}, 2'b00);
    wait_run("R9 run returns");
    chk("R8 slow gate still shut", ls_gate, 0);
    begin
      int n = 0;
      while (!ls_gate && n < 30000) begin @(negedge clk); n++; end
      chk("R8 slow gate opens", ls_gate, 1);
    end
    // R2 entry disarms
    wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    chk("R2 disarmed after entry", hs_en, 1);
    // R10 cancel at first delay edge
    arm(); wr(1'b1, 8'h01);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R10 cancel1 stop_bit", stop_bit, 0);
    repeat (3) @(negedge clk);
    chk("R10 cancel1 gates", {hs_en, osc_gate, ls_gate}, 3'b111);
    // R10 cancel at second delay edge
    arm(); wr(1'b1, 8'h01);
    @(negedge clk);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R10 cancel2 stop_bit", stop_bit, 0);
    repeat (3) @(negedge clk);
    chk("R10 cancel2 gates", {hs_en, osc_gate, ls_gate}, 3'b111);
    // R5 NMI wake
    arm(); wr(1'b1, 8'h01);
    repeat (2) @(negedge clk);
    chk("R3 stopped before nmi", hs_en, 0);
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
    chk("R5 nmi wakes", hs_en, 1);
    wait_run("R9 run after nmi");
    // random phase
    arm_st = 0;
    for (int i = 0; i < 10; i++) begin
      int nk;
      logic s, ent;
      logic [31:0] r;
      nk = 1 + ($urandom % 3);
      for (int k = 0; k < nk; k++) begin
        logic [7:0] d;
        r = $urandom;
        d = (r[1:0] == 2'd0) ? 8'h5A : (r[1:0] == 2'd1) ? 8'hA5 : r[15:8];
        wr(1'b0, d);
        arm_st = next_arm(arm_st, d);
      end
      r = $urandom;
      s = (r[1:0] != 2'd0);
      wr(1'b1, {r[8:2], s});
      ent = s && (arm_st == 2);
      if (ent) arm_st = 0;
      repeat (2) @(negedge clk);
      chk("R2 random entry", hs_en, !ent);
      if (ent) begin
        logic w;
        r = $urandom;
        pins = r[3:0]; ie = r[7:4];
        w = exp_wake(1'b0, r[3:0], r[7:4]);
        @(negedge clk);
        chk("R5 random pin wake", hs_en, w);
        pins = 4'h0; ie = 4'h0;
        if (!w) begin
          nmi = 1'b1;
          @(negedge clk);
          nmi = 1'b0;
        end
        wait_run("R9 random run");
      end
    end
    summary();
  end
endmodule